// File: doc/BRIEF.md
# Packet-Driven DRAM Command Front-End

This block sits at a memory module endpoint and turns one self-contained access packet into a timed DRAM command sequence. The packet header arrives over a narrow serial link, a few bits per cycle, and carries everything the access needs: direction, burst size, bank, starting column and row. Once the header is complete, the block opens the row, waits the row-to-column delay, and issues one column strobe per beat on consecutive cycles, stepping the column address each time. It then waits out the read latency, closes the row with a precharge, and holds off the next packet until the precharge recovery time has passed.

Data words are 64 bits wide and move on a parallel port beside the link. A write takes one word in each write-strobe cycle. A read returns one word per beat, a fixed number of cycles after its strobe. The bank array is a small behavioural memory that folds the row and column addresses onto a few low bits, so that the timing logic can be exercised end to end. A packet that starts while the block is occupied is refused with a one-cycle error pulse. Nothing else happens for that packet.

Top module: `ocf_cmd_frontend`

## Requirements
- R1: The 25-bit header is sent most significant bit first, LINK_W bits per flit, over consecutive valid cycles. The first flit carries a start mark. The field layout is bit 24 = direction (1 read, 0 write), bits 23:20 = burst code, bits 19:17 = bank, bits 16:10 = column, bits 9:0 = row. act_o is high for exactly one cycle, two cycles after the cycle that presents the last flit, with cmd_bank_o and cmd_row_o equal to the header fields.
- R2: The first column strobe (rd_o or wr_o) appears exactly TRCD cycles after act_o.
- R3: A burst code n produces n+1 column strobes on consecutive cycles. The first strobe carries the header column. Each later strobe carries the previous column plus one, modulo 128. Bank and row stay constant, and no two of act_o, rd_o/wr_o and pre_o are high together.
- R4: rdata_vld_o is high exactly TCL cycles after each read strobe. rdata_o is then the word last written to location {bank, row[MEM_ROW_BITS-1:0], column[MEM_COL_BITS-1:0]}.
- R5: In each write-strobe cycle, the value on wdata_i is stored at the location addressed by that strobe.
- R6: pre_o pulses for one cycle, TCL+1 cycles after the last column strobe of the burst.
- R7: busy_o rises in the cycle after the first flit of an accepted packet. It falls TRP+1 cycles after the pre_o cycle. No command strobe or read data appears while busy_o is low.
- R8: A start-marked flit that arrives while busy_o is high makes err_o high for one cycle in the next cycle. That packet is dropped: it produces no act_o and writes nothing. A start flit while busy_o is low never raises err_o.
- R9: During reset, act_o, rd_o, wr_o, pre_o, rdata_vld_o, busy_o and err_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_vld_i | input | 1 | A header flit is present on the link |
| link_sop_i | input | 1 | The present flit is the first of a packet |
| link_data_i | input | LINK_W | Header flit, most significant part first |
| wdata_i | input | DATA_W | Write word, sampled in each write-strobe cycle |
| act_o | output | 1 | Row activate strobe |
| rd_o | output | 1 | Read column strobe |
| wr_o | output | 1 | Write column strobe |
| pre_o | output | 1 | Precharge strobe |
| cmd_bank_o | output | 3 | Bank of the current access |
| cmd_row_o | output | 10 | Row of the current access |
| cmd_col_o | output | 7 | Column of the current strobe |
| rdata_o | output | DATA_W | Read word |
| rdata_vld_o | output | 1 | rdata_o holds a read word |
| busy_o | output | 1 | A packet is being received or executed |
| err_o | output | 1 | A packet was refused because the block was busy |

## Verification
The bench builds the block with LINK_W = 5, so that the header takes exactly five flits, and with TRCD = 4, TCL = 3 and TRP = 2 in place of the ten-cycle defaults. The shorter delays still keep every timing window distinct: TRCD, the read latency and the precharge recovery can each be measured as a separate cycle offset. They also let many packets fit in a short run. The default folded memory of MEM_ROW_BITS = 1 and MEM_COL_BITS = 4 is kept. A 16-beat burst therefore covers a full folded column range, and a burst that starts at column 126 shows the wrap of the 7-bit column and the aliasing of column 0 in one readback.

// File: rtl/ocf_pkg.sv
package ocf_pkg;
    localparam int HDR_W  = 25;
    localparam int BANK_W = 3;
    localparam int COL_W  = 7;
    localparam int ROW_W  = 10;
    localparam int BLEN_W = 4;

    typedef struct packed {
        logic              rd;
        logic [BLEN_W-1:0] blen;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
    } hdr_t;

    typedef enum logic [2:0] {
        S_IDLE, S_RCD, S_COL, S_DRAIN, S_PRE, S_RP
    } seq_state_e;
endpackage

// File: rtl/ocf_hdr_deser.sv
module ocf_hdr_deser
    import ocf_pkg::*;
#(
    parameter int LINK_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_vld_i,
    input  logic              link_sop_i,
    input  logic [LINK_W-1:0] link_data_i,
    input  logic              blocked_i,
    output logic              active_o,
    output logic              hdr_vld_o,
    output hdr_t              hdr_o,
    output logic              err_o
);
    localparam int FLITS = (HDR_W + LINK_W - 1) / LINK_W;
    localparam int SHW   = FLITS * LINK_W;
    localparam int CW    = $clog2(FLITS + 1);

    typedef struct packed {
        logic           active;
        logic [CW-1:0]  cnt;
        logic [SHW-1:0] sh;
        logic           vld;
        logic           err;
    } dz_t;

    dz_t dz_d, dz_q;

    always_comb begin
        dz_d     = dz_q;
        dz_d.vld = 1'b0;
        dz_d.err = 1'b0;
        if (link_vld_i && link_sop_i && (dz_q.active || dz_q.vld || blocked_i)) begin
            dz_d.err = 1'b1;
        end else if (!dz_q.active) begin
            if (link_vld_i && link_sop_i) begin
                dz_d.sh  = (dz_q.sh << LINK_W) | SHW'(link_data_i);
                dz_d.cnt = CW'(1);
                if (FLITS == 1) dz_d.vld    = 1'b1;
                else            dz_d.active = 1'b1;
            end
        end else if (link_vld_i) begin
            dz_d.sh  = (dz_q.sh << LINK_W) | SHW'(link_data_i);
            dz_d.cnt = dz_q.cnt + CW'(1);
            if (dz_q.cnt == CW'(FLITS - 1)) begin
                dz_d.active = 1'b0;
                dz_d.vld    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dz_q <= '0;
        else        dz_q <= dz_d;
    end

    assign active_o  = dz_q.active;
    assign hdr_vld_o = dz_q.vld;
    assign hdr_o     = hdr_t'(dz_q.sh[SHW-1 -: HDR_W]);
    assign err_o     = dz_q.err;

    // a complete header is handed over for one cycle only
    assert_hdr_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dz_q.vld |=> !dz_q.vld);
endmodule

// File: rtl/ocf_cmd_seq.sv
module ocf_cmd_seq
    import ocf_pkg::*;
#(
    parameter int TRCD = 10,
    parameter int TCL  = 10,
    parameter int TRP  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_vld_i,
    input  hdr_t              hdr_i,
    output logic              busy_o,
    output logic              act_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              pre_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o
);
    localparam int TMAX = (TRCD > TCL) ? ((TRCD > TRP) ? TRCD : TRP)
                                       : ((TCL > TRP) ? TCL : TRP);
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [TW-1:0]     cnt;
        logic [BLEN_W-1:0] beats;
        logic              rd;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              act;
        logic              stb;
        logic              pre;
    } sq_t;

    sq_t sq_d, sq_q;

    always_comb begin
        sq_d     = sq_q;
        sq_d.act = 1'b0;
        sq_d.pre = 1'b0;
        unique case (sq_q.state)
            S_IDLE: if (hdr_vld_i) begin
                sq_d.state = S_RCD;
                sq_d.act   = 1'b1;
                sq_d.cnt   = TW'(TRCD - 1);
                sq_d.rd    = hdr_i.rd;
                sq_d.beats = hdr_i.blen;
                sq_d.bank  = hdr_i.bank;
                sq_d.row   = hdr_i.row;
                sq_d.col   = hdr_i.col;
            end
            S_RCD: if (sq_q.cnt == '0) begin
                sq_d.state = S_COL;
                sq_d.stb   = 1'b1;
            end else sq_d.cnt = sq_q.cnt - TW'(1);
            S_COL: if (sq_q.beats == '0) begin
                sq_d.stb   = 1'b0;
                sq_d.state = S_DRAIN;
                sq_d.cnt   = TW'(TCL - 1);
            end else begin
                sq_d.col   = sq_q.col + COL_W'(1);
                sq_d.beats = sq_q.beats - BLEN_W'(1);
            end
            S_DRAIN: if (sq_q.cnt == '0) begin
                sq_d.state = S_PRE;
                sq_d.pre   = 1'b1;
            end else sq_d.cnt = sq_q.cnt - TW'(1);
            S_PRE: begin
                sq_d.state = S_RP;
                sq_d.cnt   = TW'(TRP - 1);
            end
            S_RP: if (sq_q.cnt == '0) sq_d.state = S_IDLE;
                  else sq_d.cnt = sq_q.cnt - TW'(1);
            default: sq_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign busy_o = (sq_q.state != S_IDLE);
    assign act_o  = sq_q.act;
    assign rd_o   = sq_q.stb && sq_q.rd;
    assign wr_o   = sq_q.stb && !sq_q.rd;
    assign pre_o  = sq_q.pre;
    assign bank_o = sq_q.bank;
    assign row_o  = sq_q.row;
    assign col_o  = sq_q.col;

    // R3: the command strobes never overlap
    assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_o, rd_o || wr_o, pre_o}));

    // R3: back-to-back strobes step the column by one and hold the bank
    assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.stb && $past(sq_q.stb)) |->
            (sq_q.col == $past(sq_q.col) + COL_W'(1)) && (sq_q.bank == $past(sq_q.bank)));

    // R7: the cycle after a precharge carries no activate or column strobe
    assert_rp_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.pre |=> !(sq_q.act || sq_q.stb));
endmodule

// File: rtl/ocf_bank_mem.sv
module ocf_bank_mem
    import ocf_pkg::*;
#(
    parameter int DATA_W       = 64,
    parameter int MEM_ROW_BITS = 1,
    parameter int MEM_COL_BITS = 4,
    parameter int TCL          = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_i,
    input  logic                    wr_i,
    input  logic [BANK_W-1:0]       bank_i,
    input  logic [MEM_ROW_BITS-1:0] row_i,
    input  logic [MEM_COL_BITS-1:0] col_i,
    input  logic [DATA_W-1:0]       wdata_i,
    output logic [DATA_W-1:0]       rdata_o,
    output logic                    rvld_o
);
    localparam int AW    = BANK_W + MEM_ROW_BITS + MEM_COL_BITS;
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     idx;
    logic [DATA_W-1:0] pipe_data [TCL];
    logic [TCL-1:0]    pipe_vld;

    assign idx = {bank_i, row_i, col_i};

    always_ff @(posedge clk) begin
        if (wr_i) mem[idx] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        pipe_data[0] <= mem[idx];
        for (int i = 1; i < TCL; i++) pipe_data[i] <= pipe_data[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_vld <= '0;
        else begin
            pipe_vld[0] <= rd_i;
            for (int i = 1; i < TCL; i++) pipe_vld[i] <= pipe_vld[i-1];
        end
    end

    assign rdata_o = pipe_data[TCL-1];
    assign rvld_o  = pipe_vld[TCL-1];
endmodule

// File: rtl/ocf_cmd_frontend.sv
module ocf_cmd_frontend
    import ocf_pkg::*;
#(
    parameter int LINK_W       = 5,
    parameter int DATA_W       = 64,
    parameter int TRCD         = 10,
    parameter int TCL          = 10,
    parameter int TRP          = 10,
    parameter int MEM_ROW_BITS = 1,
    parameter int MEM_COL_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_vld_i,
    input  logic              link_sop_i,
    input  logic [LINK_W-1:0] link_data_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              act_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              pre_o,
    output logic [2:0]        cmd_bank_o,
    output logic [9:0]        cmd_row_o,
    output logic [6:0]        cmd_col_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdata_vld_o,
    output logic              busy_o,
    output logic              err_o
);
    logic rx_active, hdr_vld, seq_busy;
    hdr_t hdr;

    ocf_hdr_deser #(.LINK_W(LINK_W)) deser_i (
        .clk(clk), .rst_n(rst_n),
        .link_vld_i(link_vld_i), .link_sop_i(link_sop_i), .link_data_i(link_data_i),
        .blocked_i(seq_busy), .active_o(rx_active),
        .hdr_vld_o(hdr_vld), .hdr_o(hdr), .err_o(err_o)
    );

    ocf_cmd_seq #(.TRCD(TRCD), .TCL(TCL), .TRP(TRP)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .hdr_vld_i(hdr_vld), .hdr_i(hdr), .busy_o(seq_busy),
        .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o),
        .bank_o(cmd_bank_o), .row_o(cmd_row_o), .col_o(cmd_col_o)
    );

    ocf_bank_mem #(.DATA_W(DATA_W), .MEM_ROW_BITS(MEM_ROW_BITS),
                   .MEM_COL_BITS(MEM_COL_BITS), .TCL(TCL)) mem_i (
        .clk(clk), .rst_n(rst_n),
        .rd_i(rd_o), .wr_i(wr_o), .bank_i(cmd_bank_o),
        .row_i(cmd_row_o[MEM_ROW_BITS-1:0]), .col_i(cmd_col_o[MEM_COL_BITS-1:0]),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .rvld_o(rdata_vld_o)
    );

    assign busy_o = rx_active || hdr_vld || seq_busy;

    // R8: a packet that starts while free is never refused
    assert_no_err_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_vld_i && link_sop_i && !busy_o) |=> !err_o);

    // R7: an idle block drives no command and returns no data
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !(act_o || rd_o || wr_o || pre_o || rdata_vld_o));
endmodule

// File: tb/ocf_cmd_frontend_tb.sv
module ocf_cmd_frontend_tb_top;
    localparam int LINK_W = 5;
    localparam int TRCD = 4, TCL = 3, TRP = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic link_vld = 1'b0, link_sop = 1'b0;
    logic [LINK_W-1:0] link_data = '0;
    logic [63:0] wdata = '0;
    logic act, rd, wr, pre, rvld, busy, err;
    logic [2:0] bank; logic [9:0] row; logic [6:0] col;
    logic [63:0] rdata;

    always #5 clk = ~clk;

    ocf_cmd_frontend #(.LINK_W(LINK_W), .TRCD(TRCD), .TCL(TCL), .TRP(TRP)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_vld_i(link_vld), .link_sop_i(link_sop),
        .link_data_i(link_data), .wdata_i(wdata), .act_o(act), .rd_o(rd), .wr_o(wr),
        .pre_o(pre), .cmd_bank_o(bank), .cmd_row_o(row), .cmd_col_o(col),
        .rdata_o(rdata), .rdata_vld_o(rvld), .busy_o(busy), .err_o(err));

    int n_chk = 0, n_bad = 0, cyc = 0, n_act = 0, wseed = 1;
    logic [63:0] model [256];
    logic [12:0] exp_act [$];
    logic [20:0] exp_stb [$];
    logic [63:0] exp_rd [$];
    logic [63:0] wq [$];
    int rd_cyc [$];
    int act_cyc = 0, last_stb = 0, pre_cyc = 0;
    bit first_stb = 0, prev_busy = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    function automatic int midx(input logic [2:0] b, input logic [9:0] r, input logic [6:0] c);
        return int'({b, r[0], c[3:0]});
    endfunction

    // driver: sends one header and, when accepted, pushes the expectations
    task automatic send(input bit isrd, input logic [3:0] bl, input logic [2:0] b,
                        input logic [6:0] c, input logic [9:0] r, input bit dropped);
        logic [24:0] h;
        h = {isrd, bl, b, c, r};
        if (!dropped) begin
            exp_act.push_back({b, r});
            for (int k = 0; k <= int'(bl); k++) begin
                logic [6:0] ck;
                ck = c + 7'(k);
                exp_stb.push_back({isrd, b, r, ck});
                if (isrd) exp_rd.push_back(model[midx(b, r, ck)]);
                else begin
                    logic [63:0] w;
                    w = {32'(wseed), ~32'(wseed * 7)};
                    wseed++;
                    wq.push_back(w);
                    model[midx(b, r, ck)] = w;
                end
            end
        end
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i == 1 && !dropped) chk(busy == 1'b1, "R7 busy after first flit", 64'(busy), 64'd1);
            if (i == 1 && dropped)  chk(err == 1'b1, "R8 err on busy start", 64'(err), 64'd1);
            link_vld  = 1'b1;
            link_sop  = (i == 0);
            link_data = h[24 - LINK_W*i -: LINK_W];
        end
        @(negedge clk);
        link_vld = 1'b0; link_sop = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // monitor and scoreboard
    always @(negedge clk) if (rst_n) begin
        if (act) begin
            logic [12:0] e;
            e = (exp_act.size() > 0) ? exp_act.pop_front() : 13'h1fff;
            chk({bank, row} == e, "R1 act bank/row", 64'({bank, row}), 64'(e));
            act_cyc = cyc; first_stb = 1; n_act++;
        end
        if (rd || wr) begin
            logic [20:0] e;
            e = (exp_stb.size() > 0) ? exp_stb.pop_front() : 21'h1fffff;
            chk({rd, bank, row, col} == e, "R3 strobe dir/bank/row/col", 64'({rd, bank, row, col}), 64'(e));
            if (first_stb) chk(cyc - act_cyc == TRCD, "R2 act to column delay", 64'(cyc - act_cyc), 64'(TRCD));
            first_stb = 0; last_stb = cyc;
            if (rd) rd_cyc.push_back(cyc);
            if (wr) wdata = (wq.size() > 0) ? wq.pop_front() : '0; // R5 write data in strobe cycle
        end
        if (rvld) begin
            logic [63:0] e;
            int c0;
            e  = (exp_rd.size() > 0) ? exp_rd.pop_front() : 64'hdead;
            c0 = (rd_cyc.size() > 0) ? rd_cyc.pop_front() : 0;
            chk(rdata == e, "R4 read data", rdata, e);
            chk(cyc - c0 == TCL, "R4 read latency", 64'(cyc - c0), 64'(TCL));
        end
        if (pre) begin
            chk(cyc - last_stb == TCL + 1, "R6 precharge timing", 64'(cyc - last_stb), 64'(TCL + 1));
            pre_cyc = cyc;
        end
        if (prev_busy && !busy)
            chk(cyc - pre_cyc == TRP + 1, "R7 busy release", 64'(cyc - pre_cyc), 64'(TRP + 1));
        prev_busy = busy;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({act, rd, wr, pre, rvld, busy, err} == 7'b0, "R9 reset quiet",
            64'({act, rd, wr, pre, rvld, busy, err}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // full 16-beat write, then a 4-beat overwrite inside it
        send(0, 4'd15, 3'd2, 7'd0, 10'd5, 0);   wait_idle();
        send(0, 4'd3,  3'd2, 7'd3, 10'd5, 0);   wait_idle();
        send(1, 4'd15, 3'd2, 7'd0, 10'd5, 0);   wait_idle();
        // column wrap 126,127,0,1 then readback of the aliased start
        send(0, 4'd15, 3'd7, 7'd0, 10'd1, 0);   wait_idle();
        send(0, 4'd3,  3'd7, 7'd126, 10'd1, 0); wait_idle();
        send(1, 4'd1,  3'd7, 7'd0, 10'd1, 0);   wait_idle();
        send(1, 4'd3,  3'd7, 7'd126, 10'd3, 0); wait_idle();
        // single beat at the field extremes
        send(0, 4'd0, 3'd0, 7'h7f, 10'h3ff, 0); wait_idle();
        send(1, 4'd0, 3'd0, 7'h7f, 10'h3ff, 0); wait_idle();
        // R8: a start during a busy packet is refused and dropped
        begin
            int a0;
            a0 = n_act;
            send(0, 4'd2, 3'd4, 7'd8, 10'd2, 0);
            send(0, 4'd5, 3'd5, 7'd9, 10'd3, 1);
            wait_idle();
            chk(n_act == a0 + 1, "R8 dropped packet gives no activate", 64'(n_act), 64'(a0 + 1));
            send(1, 4'd2, 3'd4, 7'd8, 10'd2, 0); wait_idle();
        end
        chk(exp_stb.size() == 0, "R3 strobe count", 64'(exp_stb.size()), 64'd0);
        chk(exp_rd.size() == 0, "R4 all reads returned", 64'(exp_rd.size()), 64'd0);
        chk(exp_act.size() == 0, "R1 all activates seen", 64'(exp_act.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule